// File: doc/BRIEF.md
# Serial Identifier Response Sequencer

This block is a Moore state machine that answers a request strobe by sending a fixed identifier on one serial line. The bits go out one per clock, most significant bit first. While no request is pending the machine stays idle and holds the line low. A request seen in idle starts a transmission on the next clock edge. The machine then steps through one state per identifier bit without looking at the request, and it returns to idle after the last bit.

The identifier value and its length are set at elaboration time. The default is the four-bit code 1101. A busy output frames each transmission. A second parameter chooses how the transmit position is held: either a binary counter with a decoder, or a one-hot shift chain. The behaviour at the ports is the same for both.

Top module: `serial_id_responder`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, with `sdata` = 0 and `busy` = 0 in the cycle after the reset edge. This holds even in the middle of a transmission.
- R2: While idle and with `req` at 0, the machine stays idle and `sdata` is 0.
- R3: A `req` of 1 sampled on a clock edge while idle makes the first identifier bit appear, with `busy` = 1, in the cycle that follows that edge.
- R4: Bits leave most significant first, one full clock cycle each. With the default `ID_CODE` = 4'b1101 the stream is 1,1,0,1.
- R5: Once started, the transmit states advance on every clock whatever value `req` has, so toggling `req` during a transmission does not change the stream.
- R6: After the last bit the machine returns to idle unconditionally for at least one cycle. A `req` that is high only during the last bit starts nothing.
- R7: With `req` held at 1, transmissions repeat back to back, with exactly one idle cycle between them.
- R8: `busy` is 1 for exactly `ID_LEN` consecutive cycles per transmission and 0 otherwise, and `sdata` is 0 whenever `busy` is 0.
- R9: `ID_LEN`, `ID_CODE` and `ENC` (0 = binary counter, 1 = one-hot chain) are parameters. Any length of at least 1 and either encoding give the stream described above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled only in idle |
| sdata | output | 1 | Serial identifier bit, 0 when idle |
| busy | output | 1 | High during every transmit state |

## Verification
The hardest situations to reach are the ones where `req` changes right at a state boundary. These are a request that is high only during the last bit, a request held across the return to idle, and a reset that arrives partway through a transmission. The driver places `req` edges on exact cycles relative to a pulse it has already sent, so it lands on these boundaries on purpose. A second instance with a six-bit code and the one-hot chain runs the same stimulus, which covers the other encoding and a length other than four.

// File: rtl/sid_pkg.sv
package sid_pkg;
   typedef enum logic {SID_ENC_BINARY = 1'b0, SID_ENC_ONEHOT = 1'b1} sid_enc_e;
   typedef enum logic {SID_IDLE = 1'b0, SID_SEND = 1'b1} sid_phase_e;
endpackage

// File: rtl/sid_seq_ctrl.sv
module sid_seq_ctrl #(
   parameter int                ID_LEN = 4,
   parameter sid_pkg::sid_enc_e ENC    = sid_pkg::SID_ENC_BINARY
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic [ID_LEN-1:0] slot_oh,
   output logic              busy
);
   localparam int IW = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;

   generate
      if (ENC == sid_pkg::SID_ENC_ONEHOT) begin : g_onehot
         logic [ID_LEN-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst)                 chain_q <= '0;
            else if (chain_q == '0)  chain_q <= start ? ID_LEN'(1) : '0;
            else                     chain_q <= chain_q << 1;
         end
         assign slot_oh = chain_q;
      end else begin : g_binary
         localparam logic [IW-1:0] LAST = IW'(ID_LEN - 1);
         sid_pkg::sid_phase_e phase_q;
         logic [IW-1:0]       pos_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               phase_q <= sid_pkg::SID_IDLE;
               pos_q   <= '0;
            end else if (phase_q == sid_pkg::SID_IDLE) begin
               if (start) phase_q <= sid_pkg::SID_SEND;
               pos_q <= '0;
            end else if (pos_q == LAST) begin
               phase_q <= sid_pkg::SID_IDLE;
               pos_q   <= '0;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
         always_comb begin
            for (int i = 0; i < ID_LEN; i++)
               slot_oh[i] = (phase_q == sid_pkg::SID_SEND) && (pos_q == IW'(i));
         end
      end
   endgenerate

   assign busy = |slot_oh;

   // R8: at most one transmit position active at a time
   a_r8_single_slot: assert property (@(posedge clk) disable iff (rst) $onehot0(slot_oh));
   // R2: idle without a request stays idle
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> !busy);
   // R3: a request in idle enters the first position
   a_r3_enter_first: assert property (@(posedge clk) disable iff (rst) (!busy && start) |=> slot_oh[0]);
   // R6: last position always returns to idle
   a_r6_back_to_idle: assert property (@(posedge clk) disable iff (rst) slot_oh[ID_LEN-1] |=> !busy);

   generate
      for (genvar g = 0; g < ID_LEN - 1; g++) begin : g_step
         // R5: positions advance every cycle regardless of the request
         a_r5_advance: assert property (@(posedge clk) disable iff (rst) slot_oh[g] |=> slot_oh[g+1]);
      end
   endgenerate
endmodule

// File: rtl/sid_bit_pick.sv
module sid_bit_pick #(
   parameter int                ID_LEN  = 4,
   parameter logic [ID_LEN-1:0] ID_CODE = 4'b1101
) (
   input  logic [ID_LEN-1:0] slot_oh,
   output logic              sdata
);
   logic [ID_LEN-1:0] send_order;

   generate
      for (genvar g = 0; g < ID_LEN; g++) begin : g_order
         assign send_order[g] = ID_CODE[ID_LEN-1-g];
      end
   endgenerate

   assign sdata = |(slot_oh & send_order);
endmodule

// File: rtl/serial_id_responder.sv
module serial_id_responder #(
   parameter int                ID_LEN  = 4,
   parameter logic [ID_LEN-1:0] ID_CODE = 4'b1101,
   parameter sid_pkg::sid_enc_e ENC     = sid_pkg::SID_ENC_BINARY
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   output logic sdata,
   output logic busy
);
   generate
      if (ID_LEN < 1) begin : g_bad_len
         $error("serial_id_responder: ID_LEN must be at least 1");
      end
   endgenerate

   logic [ID_LEN-1:0] slot_oh;

   sid_seq_ctrl #(.ID_LEN(ID_LEN), .ENC(ENC)) u_ctrl (
      .clk(clk), .rst(rst), .start(req), .slot_oh(slot_oh), .busy(busy)
   );

   sid_bit_pick #(.ID_LEN(ID_LEN), .ID_CODE(ID_CODE)) u_pick (
      .slot_oh(slot_oh), .sdata(sdata)
   );

   // R1: reset always yields idle on the next cycle
   a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !sdata));
   // R8: line low outside transmissions
   a_r8_quiet_line: assert property (@(posedge clk) disable iff (rst) !busy |-> !sdata);
   // R4: first bit sent is the leftmost code bit
   a_r4_first_bit: assert property (@(posedge clk) disable iff (rst) slot_oh[0] |-> (sdata == ID_CODE[ID_LEN-1]));
   // R4: last bit sent is the rightmost code bit
   a_r4_last_bit: assert property (@(posedge clk) disable iff (rst) slot_oh[ID_LEN-1] |-> (sdata == ID_CODE[0]));
endmodule

// File: tb/serial_id_responder_test.sv
module serial_id_responder_test;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_B = 6;
   localparam logic [LEN_B-1:0] CODE_B = 6'b100110;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req = 1'b0;
   logic sdata_a, busy_a, sdata_b, busy_b;
   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit started = 1'b0;
   bit done = 1'b0;
   bit q_a[$];
   bit q_b[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_id_responder uut (
      .clk(clk), .rst(rst), .req(req), .sdata(sdata_a), .busy(busy_a)
   );

   // R9: different length, code and encoding, same stimulus
   serial_id_responder #(.ID_LEN(LEN_B), .ID_CODE(CODE_B), .ENC(sid_pkg::SID_ENC_ONEHOT)) uut_oh (
      .clk(clk), .rst(rst), .req(req), .sdata(sdata_b), .busy(busy_b)
   );

   task automatic check(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] at %0t: actual %b expected %b", what, tag, $time, act, exp);
      end
   endtask

   task automatic step(input logic r, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1 req = r;
      end
   endtask

   // Monitor and scoreboard: pops one expected bit per cycle per instance
   always @(negedge clk) begin
      if (started) begin
         bit ea, eb, ba, bb;
         ba = (q_a.size() != 0);
         ea = ba ? q_a.pop_front() : 1'b0;
         bb = (q_b.size() != 0);
         eb = bb ? q_b.pop_front() : 1'b0;
         check(ba ? "R4 default sdata" : "R2 R6 idle sdata", sdata_a, ea);
         check("R8 default busy", busy_a, ba);
         check(bb ? "R4 R9 onehot sdata" : "R2 R6 R9 idle sdata", sdata_b, eb);
         check("R8 R9 onehot busy", busy_b, bb);
         if (rst) begin
            q_a.delete();
            q_b.delete();
         end else begin
            if (!ba && req) for (int i = 3; i >= 0; i--) q_a.push_back(uut.ID_CODE[i] ? 1'b1 : 1'b0);
            if (!bb && req) for (int i = LEN_B-1; i >= 0; i--) q_b.push_back(CODE_B[i]);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(1'b0, 2);
      // R1: reset state observed directly
      #(CLK_PERIOD/2);
      check("R1 reset sdata", sdata_a, 1'b0);
      check("R1 reset busy", busy_a, 1'b0);
      started = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      tag = "R2"; step(1'b0, 5);
      tag = "R3"; step(1'b1, 1); step(1'b0, 10);
      tag = "R5"; step(1'b1, 1); step(1'b0, 1); step(1'b1, 1); step(1'b0, 1); step(1'b1, 1); step(1'b0, 8);
      // R6: request only during the last default bit (3 cycles after the start bit)
      tag = "R6"; step(1'b1, 1); step(1'b0, 3); step(1'b1, 1); step(1'b0, 10);
      tag = "R7"; step(1'b1, 30); step(1'b0, 10);
      tag = "R1"; step(1'b1, 1); step(1'b0, 2);
      @(posedge clk); #1 rst = 1'b1;
      step(1'b0, 1);
      @(posedge clk); #1 rst = 1'b0;
      step(1'b0, 4);
      tag = "R3"; step(1'b1, 1); step(1'b0, 12);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule